// File: doc/BRIEF.md
# Line-Scan Camera Timing Generator

This block sequences one readout line of a line-scan image sensor driven in slave mode. When a line is requested it drives a transfer strobe to the sensor for a fixed number of pixel clocks. It then drops the strobe and waits a fixed worst-case interval, after which the sensor's video is known to be valid. Next it flags each pixel sample with a valid bit and a pixel index, and finally gives a one-cycle end-of-line pulse.

The block runs entirely on the pixel clock. A downstream capture stage only has to store the pixel data whenever the valid bit is high, using the index as its write address. Requests for a new line are never dropped. A request that arrives while a line is in progress is remembered. It is launched once the block is idle again and the strobe has been low for its minimum time.

Top module: `lscan_timing_gen`

## Requirements
- R1: While `rst_n` is low, `line_xfer`, `pix_valid` and `line_done` are low. Reset is asynchronous on assertion and released internally two clocks after `rst_n` rises. After release the block is idle, and a new line may start at once.
- R2: In idle with the low-time rule met, the clock edge that samples `start_req` high starts a line. `line_xfer` is high in the cycle right after that edge.
- R3: `line_xfer` is high for exactly HIGH_CYC consecutive cycles (default 3).
- R4: Between two transfer strobes, `line_xfer` stays low for at least LOW_MIN cycles (default 7), even when a request is waiting.
- R5: Exactly VIDEO_DLY cycles (default 71) pass with `line_xfer` and `pix_valid` both low between the fall of `line_xfer` and the first `pix_valid` cycle.
- R6: `pix_valid` is high for exactly NUM_PIX consecutive cycles (default 128). `pix_idx` is 0 in the first of them and rises by one per cycle up to NUM_PIX-1.
- R7: `line_done` is a one-cycle pulse in the cycle right after the last valid pixel. At most one of `line_xfer`, `pix_valid` and `line_done` is high in any cycle.
- R8: A `start_req` seen in any cycle of a line, even a single-cycle pulse, is held and starts exactly one further line. If `start_req` stays high, lines repeat with a period of max(HIGH_CYC+VIDEO_DLY+NUM_PIX+2, HIGH_CYC+LOW_MIN) cycles (204 with defaults).
- R9: Without a request the block stays idle with all outputs low. A request consumed by a line launch starts no second line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to read out one line |
| line_xfer | output | 1 | Transfer strobe to the sensor |
| pix_valid | output | 1 | Current cycle carries a valid pixel |
| pix_idx | output | $clog2(NUM_PIX) (7) | Index of the current pixel, 0 while not valid |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
The bound checker watches every cycle for several properties: the strobe high width, the minimum strobe low time, the exact gap from the strobe's fall to the first pixel, the pixel index stepping by one from zero, the end-of-line pulse placement and the mutual exclusion of the three flags. Only the bench scenarios can show the rest. These are that a line starts on the right edge after a request, and that a request made during a line is kept and launches exactly one more line at the period predicted. They also cover held requests repeating at that period, a reset in mid-line, and that a full default line carries exactly 128 pixels.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

  // Phases of one line readout.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XFER  = 3'd1,
    ST_DELAY = 3'd2,
    ST_PIX   = 3'd3,
    ST_DONE  = 3'd4
  } lscan_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lscan_rst_sync.sv
// Asserts asynchronously, releases after two clock edges.
module lscan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lscan_launch_gate.sv
// Holds pending line requests and enforces the minimum strobe low time.
module lscan_launch_gate #(
  parameter int LOW_MIN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic in_idle,
  input  logic xfer_on,
  output logic go
);

  localparam int LW = (LOW_MIN > 2) ? $clog2(LOW_MIN) : 1;
  localparam logic [LW-1:0] LOW_TOP = LW'(LOW_MIN - 1);

  logic [LW-1:0] low_q, low_d;
  logic          low_en;
  logic          low_met;
  logic          pend_q, pend_d, pend_en;

  // Next-state logic
  always_comb begin
    low_met = (low_q == LOW_TOP);
    go      = in_idle & low_met & (pend_q | start_req);
    // Low-time counter: cleared while strobe high, saturates at LOW_TOP.
    low_en  = xfer_on | ~low_met;
    low_d   = xfer_on ? '0 : (low_q + 1'b1);
    // Pending request: consumed by a launch, set by any other request.
    pend_en = go | start_req;
    pend_d  = ~go;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= LOW_TOP;
      pend_q <= 1'b0;
    end else begin
      if (low_en)  low_q  <= low_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/lscan_phase_seq.sv
// Line phase sequencer with one shared phase counter.
module lscan_phase_seq
  import lscan_pkg::*;
#(
  parameter int HIGH_CYC  = 3,
  parameter int VIDEO_DLY = 71,
  parameter int NUM_PIX   = 128,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  output lscan_state_e       state_q,
  output logic [CNT_W-1:0]   cnt_q
);

  localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(VIDEO_DLY - 1);
  localparam logic [CNT_W-1:0] PIX_LAST = CNT_W'(NUM_PIX - 1);

  lscan_state_e     state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             phase_end;

  // Next-state logic
  always_comb begin
    unique case (state_q)
      ST_XFER:  phase_end = (cnt_q == HI_LAST);
      ST_DELAY: phase_end = (cnt_q == DLY_LAST);
      ST_PIX:   phase_end = (cnt_q == PIX_LAST);
      default:  phase_end = 1'b0;
    endcase

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go)        state_d = ST_XFER;
      ST_XFER:  if (phase_end) state_d = ST_DELAY;
      ST_DELAY: if (phase_end) state_d = ST_PIX;
      ST_PIX:   if (phase_end) state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase

    cnt_en = (state_q != ST_IDLE);
    cnt_d  = (state_d != state_q) ? '0 : (cnt_q + 1'b1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lscan_out_dec.sv
// Decodes phase and counter into the sensor strobe and pixel flags.
module lscan_out_dec
  import lscan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 7
) (
  input  lscan_state_e     state_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             line_xfer,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_idx,
  output logic             line_done
);

  always_comb begin
    line_xfer = (state_q == ST_XFER);
    pix_valid = (state_q == ST_PIX);
    line_done = (state_q == ST_DONE);
    pix_idx   = pix_valid ? IDX_W'(cnt_q) : '0;
  end

endmodule

// File: rtl/lscan_timing_gen.sv
module lscan_timing_gen
  import lscan_pkg::*;
#(
  parameter int HIGH_CYC  = 3,
  parameter int LOW_MIN   = 7,
  parameter int VIDEO_DLY = 71,
  parameter int NUM_PIX   = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_req,
  output logic                       line_xfer,
  output logic                       pix_valid,
  output logic [$clog2(NUM_PIX)-1:0] pix_idx,
  output logic                       line_done
);

  localparam int IDX_W = $clog2(NUM_PIX);
  localparam int CNT_W = $clog2(max3(HIGH_CYC, VIDEO_DLY, NUM_PIX) + 1);

  logic             rst_core_n;
  logic             go;
  lscan_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  lscan_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lscan_launch_gate #(
    .LOW_MIN (LOW_MIN)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_req (start_req),
    .in_idle   (state_q == ST_IDLE),
    .xfer_on   (state_q == ST_XFER),
    .go        (go)
  );

  lscan_phase_seq #(
    .HIGH_CYC  (HIGH_CYC),
    .VIDEO_DLY (VIDEO_DLY),
    .NUM_PIX   (NUM_PIX),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .go      (go),
    .state_q (state_q),
    .cnt_q   (cnt_q)
  );

  lscan_out_dec #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_dec (
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .line_xfer (line_xfer),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .line_done (line_done)
  );

endmodule

// File: rtl/lscan_timing_chk.sv
module lscan_timing_chk #(
  parameter int HIGH_CYC  = 3,
  parameter int LOW_MIN   = 7,
  parameter int VIDEO_DLY = 71,
  parameter int NUM_PIX   = 128,
  parameter int IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_xfer,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_idx,
  input logic             line_done
);

  int unsigned hi_run;
  int unsigned lo_run;
  int unsigned gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= 0;
      lo_run  <= LOW_MIN;
      gap_run <= 0;
    end else begin
      hi_run  <= line_xfer ? hi_run + 1 : 0;
      lo_run  <= line_xfer ? 0 : ((lo_run < LOW_MIN) ? lo_run + 1 : lo_run);
      if (line_xfer || pix_valid) gap_run <= 0;
      else if (gap_run <= VIDEO_DLY) gap_run <= gap_run + 1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !line_xfer && !pix_valid && !line_done);

  // R3
  xfer_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_xfer) |-> hi_run == HIGH_CYC);

  // R3
  xfer_high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_xfer |-> hi_run < HIGH_CYC);

  // R4
  xfer_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_xfer) |-> lo_run >= LOW_MIN);

  // R5
  video_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> gap_run == VIDEO_DLY && $past(!line_xfer));

  // R6
  first_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> pix_idx == '0);

  // R6
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && $past(pix_valid) |-> pix_idx == $past(pix_idx) + 1'b1);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_valid) |-> line_done && $past(pix_idx) == IDX_W'(NUM_PIX - 1));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_xfer, pix_valid, line_done}));

endmodule

bind lscan_timing_gen lscan_timing_chk #(
  .HIGH_CYC  (HIGH_CYC),
  .LOW_MIN   (LOW_MIN),
  .VIDEO_DLY (VIDEO_DLY),
  .NUM_PIX   (NUM_PIX),
  .IDX_W     ($clog2(NUM_PIX))
) u_lscan_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_xfer (line_xfer),
  .pix_valid (pix_valid),
  .pix_idx   (pix_idx),
  .line_done (line_done)
);

// File: tb/test_lscan_timing_gen.sv
`timescale 1ns/1ps
module test_lscan_timing_gen;

  // Small configuration: the low-time rule dominates the line period.
  localparam int SH = 2;
  localparam int SL = 12;
  localparam int SD = 3;
  localparam int SN = 4;
  localparam int SP = ((SH + SD + SN + 2) > (SH + SL)) ? (SH + SD + SN + 2) : (SH + SL);
  // Default configuration
  localparam int WH = 3;
  localparam int WD = 71;
  localparam int WN = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic start_s, start_w;
  logic xfer_s, valid_s, done_s;
  logic [1:0] idx_s;
  logic xfer_w, valid_w, done_w;
  logic [6:0] idx_w;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lscan_timing_gen #(
    .HIGH_CYC (SH), .LOW_MIN (SL), .VIDEO_DLY (SD), .NUM_PIX (SN)
  ) i_lscan_timing_gen (
    .clk (clk), .rst_n (rst_n), .start_req (start_s),
    .line_xfer (xfer_s), .pix_valid (valid_s), .pix_idx (idx_s), .line_done (done_s)
  );

  lscan_timing_gen i_lscan_timing_gen_dflt (
    .clk (clk), .rst_n (rst_n), .start_req (start_w),
    .line_xfer (xfer_w), .pix_valid (valid_w), .pix_idx (idx_w), .line_done (done_w)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // t = cycles since the launch edge (0 = cycle right after it); t < 0 means idle.
  task automatic obs(input string req, input int t, input int h, input int d, input int n,
                     input logic x, input logic v, input int i, input logic dn);
    logic ex, ev, ed;
    int   ei;
    ex = (t >= 0) && (t < h);
    ev = (t >= h + d) && (t < h + d + n);
    ed = (t == h + d + n);
    ei = ev ? (t - h - d) : 0;
    chk({req, "/R3"}, "line_xfer", int'(x), int'(ex));
    chk({req, "/R5"}, "pix_valid", int'(v), int'(ev));
    chk({req, "/R6"}, "pix_idx",   i, ei);
    chk({req, "/R7"}, "line_done", int'(dn), int'(ed));
  endtask

  task automatic obs_s(input string req, input int t);
    obs(req, t, SH, SD, SN, xfer_s, valid_s, int'(idx_s), done_s);
  endtask

  task automatic obs_w(input string req, input int t);
    obs(req, t, WH, WD, WN, xfer_w, valid_w, int'(idx_w), done_w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int pix_cnt;
    rst_n = 1'b0;
    start_s = 1'b0;
    start_w = 1'b0;

    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      obs_s("R1", -1);
      obs_w("R1", -1);
    end
    rst_n = 1'b1;
    // R1, R9: idle after release, no request
    repeat (4) begin
      @(negedge clk);
      obs_s("R1", -1);
      obs_w("R9", -1);
    end

    // R2, R9: single-cycle request, exactly one line, then idle
    start_s = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      obs_s("R2", t);
      if (t == 0) start_s = 1'b0;
    end

    // R4, R8: held request, back-to-back lines gated by low time
    start_s = 1'b1;
    for (int t = 0; t < 3 * SP + 10; t++) begin
      @(negedge clk);
      obs_s("R4", (t < 2 * SP) ? (t % SP) : (t - 2 * SP));
      if (t == 2 * SP - 1) start_s = 1'b0;
    end

    // R8: one-cycle request during the pixel phase
    start_s = 1'b1;
    for (int t = 0; t < 2 * SP + 6; t++) begin
      @(negedge clk);
      obs_s("R8", (t < SP) ? t : (t - SP));
      if (t == 0) start_s = 1'b0;
      if (t == 5) start_s = 1'b1;
      if (t == 6) start_s = 1'b0;
    end

    // R8: request still high during the transfer strobe
    start_s = 1'b1;
    for (int t = 0; t < 2 * SP + 6; t++) begin
      @(negedge clk);
      obs_s("R8", (t < SP) ? t : (t - SP));
      if (t == 1) start_s = 1'b0;
    end

    // R1: reset in mid-line clears outputs at once
    start_s = 1'b1;
    for (int t = 0; t <= SH + SD + 1; t++) begin
      @(negedge clk);
      obs_s("R1", t);
      if (t == 0) start_s = 1'b0;
    end
    rst_n = 1'b0;
    #1;
    obs_s("R1", -1);
    repeat (2) begin
      @(negedge clk);
      obs_s("R1", -1);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      obs_s("R1", -1);
    end
    // R2: immediate launch after reset
    start_s = 1'b1;
    for (int t = 0; t < SP + 4; t++) begin
      @(negedge clk);
      obs_s("R2", t);
      if (t == 0) start_s = 1'b0;
    end

    // R6: full default line, 128 pixels
    pix_cnt = 0;
    start_w = 1'b1;
    for (int t = 0; t < WH + WD + WN + 8; t++) begin
      @(negedge clk);
      obs_w("R6", t);
      obs_s("R9", -1);
      if (valid_w) pix_cnt++;
      if (t == 0) start_w = 1'b0;
    end
    chk("R6", "pixel count", pix_cnt, WN);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule